// File: doc/BRIEF.md
# Reply Cell Inserter

This block merges a locally built reply cell into a pass-through nibble-wide cell stream that flows back toward an external control station. The reply carries read-back data or version bytes. While no reply is waiting, each nibble pulled from the upstream source is copied to the output one cycle later, frame marker included.

The reply is requested with a one-cycle pulse. Its payload bytes must already have been written into a small local store. When a reply is pending, the block waits for a free slot in the stream. A free slot is either the final nibble of a through-cell or an idle nibble while no cell is in flight. At that slot it drops the read-clock enable of the upstream source, so the source holds its current nibble. It then emits a complete framed cell of its own and restores the enable. No through-cell is ever split or lost, and no cell-sized buffer is needed.

Only one reply can be outstanding at a time. The reply VCI and byte count are captured when the request is accepted.

Top module: `rsp_cell_inserter`

## Requirements
- R1: During and right after synchronous reset, `dn_nib` is 0, `dn_frm` is 0, `rsp_done` is 0 and `up_rd_en` is 1.
- R2: With no insertion in progress, a nibble consumed at a clock edge (while `up_rd_en` is 1) appears on `dn_nib`/`dn_frm` right after that edge, unchanged.
- R3: A generated cell is 106 nibbles long, high nibble of each byte first. Its header bytes are 0x00, {0x0, VCI[15:12]}, VCI[11:4] and {VCI[3:0], 0x0}. The fifth header byte is the CRC-8 (polynomial x^8+x^2+x+1, zero start, MSB first) of those four bytes, XORed with 0x55.
- R4: Payload byte k (0..47) of the generated cell equals the stored byte at address k when k < count, and zero otherwise. A requested count above 32 is treated as 32.
- R5: `dn_frm` is 1 on the first nibble of the generated cell and 0 on its other 105 nibbles.
- R6: If a through-cell is in flight, the first generated nibble is output in the cycle right after that cell's final nibble. Otherwise it follows the first idle non-frame nibble offered after the request. An offered frame start is not a free slot.
- R7: `up_rd_en` is low for exactly 106 cycles per insertion. No upstream nibble is consumed then, and the stream resumes afterwards with the held nibble, so a cell offered back-to-back emerges intact.
- R8: `rsp_done` is high for one cycle, together with the last generated nibble on the output. `up_rd_en` is high again in that same cycle.
- R9: While a reply is pending or being sent, further `rsp_req` pulses and payload-store writes are ignored. No second cell follows.
- R10: The reply VCI and count are captured when the request is accepted. Later changes on those inputs do not alter the pending reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_nib | input | 4 | Nibble offered by the upstream source |
| up_frm | input | 1 | High on the first nibble of an upstream cell |
| up_rd_en | output | 1 | Read-clock enable to the upstream source; a nibble is consumed at each edge where it is high |
| ld_we | input | 1 | Payload store write strobe |
| ld_addr | input | 5 | Payload store byte address |
| ld_data | input | 8 | Payload store write data |
| reply_vci | input | 16 | VCI to place in the reply header |
| rsp_len | input | 6 | Number of valid payload bytes |
| rsp_req | input | 1 | Request pulse for one reply cell |
| dn_nib | output | 4 | Outgoing nibble stream |
| dn_frm | output | 1 | High on the first nibble of each outgoing cell |
| rsp_done | output | 1 | One-cycle pulse on the last generated nibble |

## Verification
The decision to start an insertion and the consumption of a through-nibble fall in the same cycle. The final nibble of a cell is passed through on the same edge that stalls the source. A back-to-back frame start that is offered in that edge's wake must be held, not dropped. The bench issues requests at offsets around cell boundaries: just before a frame start, mid-cell, on and just after a final nibble, in idle gaps, and between two adjoining cells. It predicts the exact output cycle of the first generated nibble from the stream layout. Every output nibble, the enable and the done pulse are then compared against the upstream sequence with the computed cell spliced in. A second request, a store write and a VCI change are also driven while the first reply is in flight.

// File: rtl/rci_pkg.sv
package rci_pkg;

  localparam int NIB_W     = 4;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 5;
  localparam int VCI_W     = 16;

  // header check byte: CRC-8, x^8+x^2+x+1, zero start, MSB first, then xor 0x55
  function automatic logic [7:0] hec_of(input logic [31:0] hdr);
    logic [7:0] crc;
    logic       fb;
    crc = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb  = crc[7] ^ hdr[i];
      crc = {crc[6:0], 1'b0};
      if (fb) crc = crc ^ 8'h07;
    end
    return crc ^ 8'h55;
  endfunction

endpackage

// File: rtl/rci_payload_ram.sv
module rci_payload_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rci_slot_track.sv
module rci_slot_track #(
  parameter int CELL_NIBS = 106
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         take,
  input  logic                         frm,
  output logic                         in_last,
  output logic                         in_gap,
  output logic [$clog2(CELL_NIBS)-1:0] cnt_o
);

  localparam int CW = $clog2(CELL_NIBS);

  // nibbles of the current through-cell still to arrive, 0 = between cells
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (take) begin
      if (cnt_q == '0) begin
        if (frm) cnt_q <= CW'(CELL_NIBS - 1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign in_last = take && (cnt_q == CW'(1));
  assign in_gap  = take && (cnt_q == '0) && !frm;
  assign cnt_o   = cnt_q;

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < CELL_NIBS);

  a_r7_frozen_when_stalled: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(cnt_q));

endmodule

// File: rtl/rci_cell_gen.sv
module rci_cell_gen
  import rci_pkg::*;
#(
  parameter int MAX_BYTES  = 32,
  parameter int CELL_BYTES = 53
) (
  input  logic [$clog2(CELL_BYTES*2)-1:0] idx,
  input  logic [VCI_W-1:0]                vci,
  input  logic [BYTE_W-1:0]               hec,
  input  logic [$clog2(MAX_BYTES+1)-1:0]  len,
  input  logic [BYTE_W-1:0]               ram_q,
  output logic [$clog2(MAX_BYTES)-1:0]    rd_addr,
  output logic [NIB_W-1:0]                nib
);

  localparam int IW = $clog2(CELL_BYTES*2);
  localparam int AW = $clog2(MAX_BYTES);

  logic [IW:0]       nxt;
  logic [IW-1:0]     nb_next;
  logic [IW-1:0]     nb_cur;
  logic [IW-1:0]     pay_idx;
  logic [BYTE_W-1:0] cur_byte;

  // look one nibble ahead so the registered store output lines up
  always_comb begin
    nxt     = {1'b0, idx} + 1'b1;
    nb_next = nxt[IW:1];
    if (int'(nb_next) >= HDR_BYTES) rd_addr = AW'(int'(nb_next) - HDR_BYTES);
    else                            rd_addr = '0;
  end

  always_comb begin
    nb_cur  = {1'b0, idx[IW-1:1]};
    pay_idx = IW'(int'(nb_cur) - HDR_BYTES);
    case (int'(nb_cur))
      0:       cur_byte = 8'h00;
      1:       cur_byte = {4'h0, vci[15:12]};
      2:       cur_byte = vci[11:4];
      3:       cur_byte = {vci[3:0], 4'h0};
      4:       cur_byte = hec;
      default: cur_byte = (int'(pay_idx) < int'(len)) ? ram_q : 8'h00;
    endcase
    nib = idx[0] ? cur_byte[3:0] : cur_byte[7:4];
  end

endmodule

// File: rtl/rsp_cell_inserter.sv
module rsp_cell_inserter
  import rci_pkg::*;
#(
  parameter int MAX_BYTES  = 32,
  parameter int CELL_BYTES = 53
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [3:0]                     up_nib,
  input  logic                           up_frm,
  output logic                           up_rd_en,
  input  logic                           ld_we,
  input  logic [$clog2(MAX_BYTES)-1:0]   ld_addr,
  input  logic [7:0]                     ld_data,
  input  logic [15:0]                    reply_vci,
  input  logic [$clog2(MAX_BYTES+1)-1:0] rsp_len,
  input  logic                           rsp_req,
  output logic [3:0]                     dn_nib,
  output logic                           dn_frm,
  output logic                           rsp_done
);

  localparam int AW        = $clog2(MAX_BYTES);
  localparam int LW        = $clog2(MAX_BYTES + 1);
  localparam int CELL_NIBS = CELL_BYTES * 2;
  localparam int IW        = $clog2(CELL_NIBS);

  logic              pend_q, ins_q, rd_en_q, done_q;
  logic [IW-1:0]     idx_q;
  logic [VCI_W-1:0]  vci_q;
  logic [BYTE_W-1:0] hec_q;
  logic [LW-1:0]     len_q;
  logic [NIB_W-1:0]  dn_nib_q;
  logic              dn_frm_q;

  logic              trk_last, trk_gap;
  logic [IW-1:0]     trk_cnt;
  logic [AW-1:0]     rd_addr;
  logic [BYTE_W-1:0] ram_q;
  logic [NIB_W-1:0]  gen_nib;
  logic              start, last_idx, accept;

  rci_slot_track #(.CELL_NIBS(CELL_NIBS)) u_trk (
    .clk     (clk),
    .rst     (rst),
    .take    (rd_en_q),
    .frm     (up_frm),
    .in_last (trk_last),
    .in_gap  (trk_gap),
    .cnt_o   (trk_cnt)
  );

  rci_payload_ram #(.DEPTH(MAX_BYTES), .AW(AW), .DW(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (ld_we && !pend_q),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (rd_addr),
    .rdata (ram_q)
  );

  rci_cell_gen #(.MAX_BYTES(MAX_BYTES), .CELL_BYTES(CELL_BYTES)) u_gen (
    .idx     (idx_q),
    .vci     (vci_q),
    .hec     (hec_q),
    .len     (len_q),
    .ram_q   (ram_q),
    .rd_addr (rd_addr),
    .nib     (gen_nib)
  );

  assign accept   = rsp_req && !pend_q;
  assign start    = pend_q && !ins_q && rd_en_q && (trk_last || trk_gap);
  assign last_idx = (idx_q == IW'(CELL_NIBS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      ins_q    <= 1'b0;
      rd_en_q  <= 1'b1;
      done_q   <= 1'b0;
      idx_q    <= '0;
      vci_q    <= '0;
      hec_q    <= '0;
      len_q    <= '0;
      dn_nib_q <= '0;
      dn_frm_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pend_q <= 1'b1;
        vci_q  <= reply_vci;
        hec_q  <= hec_of({8'h00, 4'h0, reply_vci, 4'h0});
        len_q  <= (int'(rsp_len) > MAX_BYTES) ? LW'(MAX_BYTES) : rsp_len;
      end
      if (start) begin
        ins_q   <= 1'b1;
        idx_q   <= '0;
        rd_en_q <= 1'b0;
      end
      if (ins_q) begin
        if (last_idx) begin
          ins_q   <= 1'b0;
          rd_en_q <= 1'b1;
          pend_q  <= 1'b0;
          done_q  <= 1'b1;
          idx_q   <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
        dn_nib_q <= gen_nib;
        dn_frm_q <= (idx_q == '0);
      end else begin
        dn_nib_q <= up_nib;
        dn_frm_q <= up_frm;
      end
    end
  end

  assign up_rd_en = rd_en_q;
  assign dn_nib   = dn_nib_q;
  assign dn_frm   = dn_frm_q;
  assign rsp_done = done_q;

  a_r6_start_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(ins_q) |-> (trk_cnt == '0));

  a_r7_stalled_while_sending: assert property (@(posedge clk) disable iff (rst)
    ins_q |-> !up_rd_en);

  a_r5_frame_only_first: assert property (@(posedge clk) disable iff (rst)
    (ins_q && idx_q != '0) |=> !dn_frm);

  a_r8_done_reopens: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> up_rd_en);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r10_capture_held: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> ($stable(vci_q) && $stable(len_q)));

endmodule

// File: tb/sim_rsp_cell_inserter.sv
module sim_rsp_cell_inserter;

  localparam int SLEN = 600;
  localparam int CN   = 106;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] up_nib;
  logic       up_frm;
  logic       up_rd_en;
  logic       ld_we = 1'b0;
  logic [4:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [15:0] reply_vci = '0;
  logic [5:0] rsp_len = '0;
  logic       rsp_req = 1'b0;
  logic [3:0] dn_nib;
  logic       dn_frm;
  logic       rsp_done;

  int nvec = 0;
  int nerr = 0;
  int ptr;

  logic [3:0] s_nib [SLEN];
  logic       s_frm [SLEN];
  logic [7:0] bm [32];
  logic [3:0] g_nib [CN];

  always #4 clk = ~clk;

  rsp_cell_inserter u0 (
    .clk(clk), .rst(rst), .up_nib(up_nib), .up_frm(up_frm), .up_rd_en(up_rd_en),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data), .reply_vci(reply_vci),
    .rsp_len(rsp_len), .rsp_req(rsp_req), .dn_nib(dn_nib), .dn_frm(dn_frm),
    .rsp_done(rsp_done)
  );

  always @(posedge clk) begin
    if (rst) ptr <= 0;
    else if (up_rd_en) ptr <= ptr + 1;
  end

  assign up_nib = (ptr < SLEN) ? s_nib[ptr] : 4'hA;
  assign up_frm = (ptr < SLEN) ? s_frm[ptr] : 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // offset of stream position q inside a through-cell, -1 when idle
  function automatic int cell_off(input int q, output int cnum);
    int starts [4] = '{4, 110, 220, 326};
    cnum = -1;
    for (int i = 0; i < 4; i++)
      if (q >= starts[i] && q < starts[i] + CN) begin
        cnum = i;
        return q - starts[i];
      end
    return -1;
  endfunction

  function automatic logic [7:0] crc_hec(input logic [7:0] b0, b1, b2, b3);
    logic [39:0] sh;
    sh = {b0, b1, b2, b3, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (sh[i]) sh[i -: 9] = sh[i -: 9] ^ 9'h107;
    return sh[7:0] ^ 8'h55;
  endfunction

  task automatic build(input logic [15:0] vci, input int len);
    int cn, off, le;
    logic [7:0] gb [53];
    for (int q = 0; q < SLEN; q++) begin
      off = cell_off(q, cn);
      if (off >= 0) begin
        s_nib[q] = 4'((cn * 5 + off * 3) % 16);
        s_frm[q] = (off == 0);
      end else begin
        s_nib[q] = 4'hA;
        s_frm[q] = 1'b0;
      end
    end
    for (int k = 0; k < 32; k++) bm[k] = 8'((k * 29 + len * 3 + 5) % 256);
    le = (len > 32) ? 32 : len;
    gb[0] = 8'h00;
    gb[1] = {4'h0, vci[15:12]};
    gb[2] = vci[11:4];
    gb[3] = {vci[3:0], 4'h0};
    gb[4] = crc_hec(gb[0], gb[1], gb[2], gb[3]);
    for (int k = 0; k < 48; k++) gb[5 + k] = (k < le) ? bm[k] : 8'h00;
    for (int k = 0; k < CN; k++) g_nib[k] = (k % 2 == 0) ? gb[k / 2][7:4] : gb[k / 2][3:0];
  endtask

  task automatic run(input int sc, input int len, input int qreq);
    logic [15:0] vci;
    int qs, off, cn;
    vci = 16'h1234 ^ 16'(sc * 16'h0951);
    build(vci, len);
    @(negedge clk);
    rst = 1'b1;
    for (int k = 0; k < 32; k++) begin
      ld_we = 1'b1; ld_addr = 5'(k); ld_data = bm[k];
      @(negedge clk);
    end
    ld_we = 1'b0;
    reply_vci = vci;
    rsp_len = 6'(len);
    chk("R1 dn_nib", dn_nib, 0);
    chk("R1 dn_frm", dn_frm, 0);
    chk("R1 done", rsp_done, 0);
    chk("R1 rd_en", up_rd_en, 1);
    rst = 1'b0;
    while (ptr != qreq) begin
      if (ptr > 0) begin
        chk("R2 pass nib", dn_nib, s_nib[ptr - 1]);
        chk("R2 pass frm", dn_frm, s_frm[ptr - 1]);
      end
      @(negedge clk);
    end
    rsp_req = 1'b1;
    @(negedge clk);
    rsp_req = 1'b0;
    chk("R2 pass nib", dn_nib, s_nib[qreq]);
    // free slot search per R6
    qs = qreq + 1;
    forever begin
      off = cell_off(qs, cn);
      if (off == CN - 1 || off < 0) break;
      qs++;
    end
    for (int q = qreq + 1; q <= qs; q++) begin
      @(negedge clk);
      chk("R2 pass nib", dn_nib, s_nib[q]);
      chk("R2 pass frm", dn_frm, s_frm[q]);
      chk("R7 rd_en before", up_rd_en, (q == qs) ? 0 : 1);
      chk("R8 no done", rsp_done, 0);
    end
    // disturbances while the reply is in flight (R9, R10)
    rsp_req = 1'b1; ld_we = 1'b1; ld_addr = 5'd0; ld_data = ~bm[0];
    reply_vci = ~vci; rsp_len = 6'd3;
    for (int k = 0; k < CN; k++) begin
      @(negedge clk);
      if (k == 2) begin
        rsp_req = 1'b0; ld_we = 1'b0; reply_vci = vci; rsp_len = 6'(len);
      end
      if (k == 0)       chk("R6 first generated nibble", dn_nib, g_nib[k]);
      else if (k < 10)  chk("R3/R10 header nibble", dn_nib, g_nib[k]);
      else if (k < 12)  chk("R4/R9 payload byte0", dn_nib, g_nib[k]);
      else              chk("R4 payload nibble", dn_nib, g_nib[k]);
      chk("R5 frame", dn_frm, (k == 0) ? 1 : 0);
      chk("R7 rd_en stalled", up_rd_en, (k == CN - 1) ? 1 : 0);
      chk("R8 done", rsp_done, (k == CN - 1) ? 1 : 0);
    end
    for (int q = qs + 1; q <= qs + 130; q++) begin
      @(negedge clk);
      chk("R7/R9 resumed nib", dn_nib, s_nib[q]);
      chk("R7/R9 resumed frm", dn_frm, s_frm[q]);
      chk("R9 rd_en", up_rd_en, 1);
      chk("R9 no done", rsp_done, 0);
    end
  endtask

  initial begin
    int lens [5] = '{0, 1, 17, 32, 45};
    int qrs [10] = '{0, 3, 50, 108, 109, 214, 215, 218, 219, 325};
    int sc;
    sc = 0;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 10; j++) begin
        run(sc, lens[i], qrs[j]);
        sc++;
      end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nvec++;
    nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule